// File: doc/BRIEF.md
# Circular Trace Buffer Write Controller

This block decides where each incoming trace packet lands in a RAM used as a power-of-two ring. It holds a control word and a position word. The control word carries a size field, two trigger enables, a halt request and the main trace enable. The position word carries the write pointer and a sticky wrap flag. Every accepted 8-byte packet is issued as one RAM write at the pointer's byte address. The pointer then advances, but only inside the low bits that the size field selects. The upper bits stay put, so the ring can sit at any base that is aligned to its own size.

External start and stop inputs switch tracing on and off without software. A stop never cuts short a RAM write already issued: the write stays on the RAM port until the RAM accepts it. The halt request bit reaches the debug halt output only while the debug-enable input is high.

Top module: `trace_ring_ctrl`

## Requirements
- R1: After reset both register read ports return zero, and `ram_we`, `pkt_ready` and `dbg_halt` are low.
- R2: While tracing is enabled, a packet taken on `pkt_valid && pkt_ready` appears on the RAM port on the next cycle. `ram_addr` equals the pointer times 8, so `ram_addr[2:0]` is zero, and `ram_wdata` equals the packet. The pointer has advanced by one at that point, and back-to-back packets go to consecutive 8-byte slots.
- R3: Let the size field be M, the pointer width PW = AW-3 and the ring size 2^(M+4) bytes. An advance from a pointer whose bits [M:0] are all ones clears those bits, keeps bits above M, and sets the wrap flag. Other advances add one to bits [M:0] only. The wrap flag stays set until the position word is written.
- R4: A size field above AW-4 (28 by default) behaves exactly like AW-4.
- R5: With the start-enable bit set, a high `trig_start` sets the trace enable on the next clock. With the start-enable bit clear, `trig_start` has no effect.
- R6: With the stop-enable bit set, a high `trig_stop` clears the trace enable on the next clock. With the stop-enable bit clear, `trig_stop` has no effect.
- R7: A pending RAM write keeps `ram_we`, `ram_addr` and `ram_wdata` unchanged until `ram_ready` is high, even if tracing stops meanwhile. No packet is accepted while a write stalls or while tracing is disabled.
- R8: Sources of the next trace enable rank as follows: an enabled stop first, then an enabled start, then a software write of the control word. The trigger enables in force are those held before that write.
- R9: `dbg_halt` is high exactly when the halt bit is set and `dbg_en` is high.
- R10: Control word layout: bits [4:0] size field (read back as written), bit 5 start enable, bit 6 stop enable, bit 9 halt request, bit 31 trace enable; other bits read zero. Position word layout: bits [AW-1:3] pointer, bit 0 wrap flag, other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| pos_wr | input | 1 | Write strobe for the position word |
| pos_wdata | input | 32 | Position word write data |
| pos_rdata | output | 32 | Position word read data |
| trig_start | input | 1 | Hardware start trigger |
| trig_stop | input | 1 | Hardware stop trigger |
| dbg_en | input | 1 | Debug enable gating the halt output |
| dbg_halt | output | 1 | Debug halt request |
| pkt_valid | input | 1 | Trace packet valid |
| pkt_data | input | DW | Trace packet payload |
| pkt_ready | output | 1 | Controller can take a packet |
| ram_we | output | 1 | RAM write request |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | DW | RAM write data |
| ram_ready | input | 1 | RAM accepts the pending write |

## Verification
A bad pointer or a bad clamp of the size field shows on `ram_addr` one cycle after the packet is taken. The position read port shows it in the same cycle, as a stray carry into the upper bits or a missing wrap flag. A wrong enable update shows on bit 31 of the control read one clock after the trigger. A write dropped under stall shows as `ram_we` falling, or as `ram_addr` moving, before `ram_ready` rises. The wrap checks sweep small, middle, top and oversize size fields from pointers chosen so that a plain binary increment would give a different answer.

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic          pos_wr,
  input  logic [31:0]   pos_wdata,
  output logic [31:0]   pos_rdata,
  input  logic          trig_start,
  input  logic          trig_stop,
  input  logic          dbg_en,
  output logic          dbg_halt,
  input  logic          pkt_valid,
  input  logic [DW-1:0] pkt_data,
  output logic          pkt_ready,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic          ram_ready
);
  localparam int PW = AW - 3;
  localparam logic [4:0] MAXM = 5'(AW - 4);

  logic [4:0]    size_f;
  logic          start_en, stop_en, halt_b, en;
  logic [PW-1:0] ptr;
  logic          wrap;

  logic [4:0]    m_eff;
  logic [PW:0]   span;
  logic [PW-1:0] lowmask, ptr_inc, ptr_nxt;
  logic          carry, acc, do_stop, do_start;

  assign m_eff   = (size_f > MAXM) ? MAXM : size_f;
  assign span    = ({{PW{1'b0}}, 1'b1} << ({1'b0, m_eff} + 6'd1)) - 1'b1;
  assign lowmask = span[PW-1:0];
  assign ptr_inc = ptr + 1'b1;
  assign ptr_nxt = (ptr & ~lowmask) | (ptr_inc & lowmask);
  assign carry   = (ptr & lowmask) == lowmask;

  assign pkt_ready = en && (!ram_we || ram_ready);
  assign acc       = pkt_valid && pkt_ready;
  assign do_stop   = stop_en && trig_stop;
  assign do_start  = start_en && trig_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_f   <= '0;
      start_en <= 1'b0;
      stop_en  <= 1'b0;
      halt_b   <= 1'b0;
      en       <= 1'b0;
    end else begin
      if (ctl_wr) begin
        size_f   <= ctl_wdata[4:0];
        start_en <= ctl_wdata[5];
        stop_en  <= ctl_wdata[6];
        halt_b   <= ctl_wdata[9];
      end
      if (do_stop)       en <= 1'b0;
      else if (do_start) en <= 1'b1;
      else if (ctl_wr)   en <= ctl_wdata[31];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      wrap <= 1'b0;
    end else if (pos_wr) begin
      ptr  <= pos_wdata[AW-1:3];
      wrap <= pos_wdata[0];
    end else if (acc) begin
      ptr  <= ptr_nxt;
      if (carry) wrap <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else if (acc) begin
      ram_we    <= 1'b1;
      ram_addr  <= {ptr, 3'b000};
      ram_wdata <= pkt_data;
    end else if (ram_ready) begin
      ram_we    <= 1'b0;
    end
  end

  assign ctl_rdata = {en, 21'd0, halt_b, 2'b00, stop_en, start_en, size_f};
  assign pos_rdata = 32'({ptr, 2'b00, wrap});
  assign dbg_halt  = halt_b & dbg_en;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_addr[2:0] == 3'b000); // R2

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pos_wr && !ctl_wr) |=> (((ptr ^ $past(ptr)) & ~$past(lowmask)) == '0)); // R3

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !pos_wr) |=> wrap); // R3

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_start && !do_stop) |=> en); // R5

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> !en && !pkt_ready); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ram_ready) |=> ram_we && $stable(ram_addr) && $stable(ram_wdata)); // R7

  AST_HALT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt |-> dbg_en) and (!dbg_en |-> !dbg_halt)); // R9
endmodule

// File: tb/trace_ring_ctrl_test.sv
module trace_ring_ctrl_test;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr = 1'b0, pos_wr = 1'b0;
  logic [31:0]   ctl_wdata = '0, pos_wdata = '0;
  logic [31:0]   ctl_rdata, pos_rdata;
  logic          trig_start = 1'b0, trig_stop = 1'b0, dbg_en = 1'b0, dbg_halt;
  logic          pkt_valid = 1'b0, pkt_ready;
  logic [DW-1:0] pkt_data = '0;
  logic          ram_we, ram_ready = 1'b1;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trace_ring_ctrl #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .pos_wr(pos_wr), .pos_wdata(pos_wdata), .pos_rdata(pos_rdata),
    .trig_start(trig_start), .trig_stop(trig_stop),
    .dbg_en(dbg_en), .dbg_halt(dbg_halt),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_ready(ram_ready)
  );

  localparam int NV = 8;
  localparam logic [4:0]  V_M   [NV] = '{5'd0, 5'd0, 5'd3, 5'd3, 5'd10, 5'd27, 5'd31, 5'd29};
  localparam logic [28:0] V_P   [NV] = '{29'h100, 29'h101, 29'h1237, 29'h123F,
                                         29'h1237FF, 29'h1FFFFFFF, 29'h1FFFFFFF, 29'h0ABC};
  localparam logic [28:0] V_N   [NV] = '{29'h101, 29'h100, 29'h1238, 29'h1230,
                                         29'h123000, 29'h10000000, 29'h0, 29'h0ABD};
  localparam logic        V_W   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_both(input logic [31:0] c, input logic [31:0] p);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = c; pos_wr = 1'b1; pos_wdata = p;
    @(negedge clk); ctl_wr = 1'b0; pos_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl", 64'(ctl_rdata), 64'h0);
    check("R1 pos", 64'(pos_rdata), 64'h0);
    check("R1 ram_we", 64'(ram_we), 64'h0);
    check("R1 pkt_ready", 64'(pkt_ready), 64'h0);
    check("R1 dbg_halt", 64'(dbg_halt), 64'h0);

    wr_ctl(32'hFFFF_FFFF);
    check("R10 ctl layout", 64'(ctl_rdata), 64'h8000_027F);
    wr_both(32'h0, 32'hFFFF_FFFF);
    check("R10 pos layout", 64'(pos_rdata), 64'hFFFF_FFF9);

    // R3 R4 wrap table
    for (int i = 0; i < NV; i++) begin
      wr_both(32'h8000_0000 | 32'(V_M[i]), {V_P[i], 3'b000});
      pkt_valid = 1'b1; pkt_data = 64'hA5A5_0000_0000_0000 | 64'(i);
      @(negedge clk);
      pkt_valid = 1'b0;
      check("R2 table addr", 64'(ram_addr), 64'({V_P[i], 3'b000}));
      check("R2 table we", 64'(ram_we), 64'h1);
      check(V_M[i] > 5'd28 ? "R4 clamp pos" : "R3 wrap pos",
            64'(pos_rdata), 64'({V_N[i], 2'b00, V_W[i]}));
    end

    // R2 back-to-back
    wr_both(32'h8000_001F, 32'h200);
    pkt_valid = 1'b1; pkt_data = 64'h1111;
    @(negedge clk);
    check("R2 first addr", 64'(ram_addr), 64'h200);
    check("R2 first data", ram_wdata, 64'h1111);
    pkt_data = 64'h2222;
    @(negedge clk);
    pkt_valid = 1'b0;
    check("R2 second addr", 64'(ram_addr), 64'h208);
    check("R2 second data", ram_wdata, 64'h2222);
    check("R2 pos", 64'(pos_rdata), 64'h210);
    @(negedge clk);
    check("R2 idle", 64'(ram_we), 64'h0);

    // R5 start
    wr_ctl(32'h0000_0000);
    @(negedge clk); trig_start = 1'b1;
    @(negedge clk); trig_start = 1'b0;
    check("R5 start ignored", 64'(ctl_rdata[31]), 64'h0);
    wr_ctl(32'h0000_0020);
    @(negedge clk); trig_start = 1'b1;
    @(negedge clk); trig_start = 1'b0;
    check("R5 start sets", 64'(ctl_rdata[31]), 64'h1);

    // R6 stop
    wr_ctl(32'h8000_0000);
    @(negedge clk); trig_stop = 1'b1;
    @(negedge clk); trig_stop = 1'b0;
    check("R6 stop ignored", 64'(ctl_rdata[31]), 64'h1);
    wr_ctl(32'h8000_0040);
    @(negedge clk); trig_stop = 1'b1;
    @(negedge clk); trig_stop = 1'b0;
    check("R6 stop clears", 64'(ctl_rdata[31]), 64'h0);

    // R7 write in flight across stop
    wr_both(32'h8000_005F, 32'h0);
    ram_ready = 1'b0; pkt_valid = 1'b1; pkt_data = 64'hDEAD_BEEF;
    @(negedge clk);
    pkt_data = 64'h5555; trig_stop = 1'b1;
    check("R7 stall ready", 64'(pkt_ready), 64'h0);
    @(negedge clk);
    trig_stop = 1'b0;
    check("R7 stopped", 64'(ctl_rdata[31]), 64'h0);
    check("R7 held we", 64'(ram_we), 64'h1);
    check("R7 held addr", 64'(ram_addr), 64'h0);
    check("R7 held data", ram_wdata, 64'hDEAD_BEEF);
    check("R7 one accepted", 64'(pos_rdata), 64'h8);
    ram_ready = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    check("R7 released", 64'(ram_we), 64'h0);
    check("R7 no accept when off", 64'(pos_rdata), 64'h8);

    // R8 priorities
    wr_ctl(32'h0000_0060);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 32'h8000_0060; trig_start = 1'b1; trig_stop = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; trig_start = 1'b0; trig_stop = 1'b0;
    check("R8 stop wins", 64'(ctl_rdata[31]), 64'h0);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 32'h0000_0060; trig_start = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; trig_start = 1'b0;
    check("R8 start beats write", 64'(ctl_rdata[31]), 64'h1);

    // R9 halt gating
    wr_ctl(32'h0000_0200);
    dbg_en = 1'b0; #1;
    check("R9 gated off", 64'(dbg_halt), 64'h0);
    dbg_en = 1'b1; #1;
    check("R9 asserted", 64'(dbg_halt), 64'h1);
    wr_ctl(32'h0000_0000);
    check("R9 cleared", 64'(dbg_halt), 64'h0);

    finish_run();
  end
endmodule